// File: doc/BRIEF.md
# Cache Request-Port Stall Controller

This block decides when the processor-facing request port of a cache has to refuse new requests, and when it may take them again. It follows the occupancy of two allocation queues, one for outstanding misses and one for writes waiting to go downstream. Each cause that can stall the port owns one bit of a stall mask. A queue sets its bit when an allocation fills it. It clears the bit when marking one of its entries in service brings it back below full. A third cause, lack of free target slots, is raised and dropped by explicit inputs.

The port stays stalled while any mask bit is set. When the last bit drops, a one-cycle retry pulse goes out, but only if a request arrived during the stall. Per-cause counters record how often a stall began and how long stalls lasted. The whole stall length is charged to the cause whose release ended it. Every allocation receives its address with the block offset cleared and a sequence number that keeps increasing.

Top module: `cache_stall_ctrl`

## Requirements
- R1: After reset the stall mask, `port_blocked`, `retry_pulse`, every event and cycle counter, both error flags and the sequence number are all zero.
- R2: An accepted allocation that brings a queue's occupancy to its depth sets that queue's mask bit at the same clock edge. The miss queue uses bit 0 and the write queue uses bit 1. `port_blocked` is high in the following cycle.
- R3: A queue's mask bit is cleared only by an in-service mark given while that queue is full. An in-service mark on a queue that is not full leaves the mask unchanged.
- R4: `tgt_set` sets mask bit 2 and `tgt_clr` clears it. When both are high in the same cycle, the bit ends up set.
- R5: When the mask is zero and one or more causes become set, the event counter of the lowest-numbered such cause goes up by one. Setting a cause while the mask is already nonzero changes no event counter. Counter i sits at bits [i*CNT_W +: CNT_W].
- R6: `port_blocked` is high exactly while the mask is nonzero. When the mask returns to zero, the number of cycles `port_blocked` was high is added to the cycle counter of the lowest-numbered cause released at that edge.
- R7: `retry_pulse` is high for exactly one cycle, the first cycle after the mask returns to zero, and only if `req_valid` was seen while `port_blocked` was high. Otherwise it stays low.
- R8: `mq_tag_addr` and `wb_tag_addr` equal the matching allocation address with its low log2(BLK_BYTES) bits forced to zero.
- R9: Sequence numbers start at 0 and advance once per accepted allocation. When both queues allocate in the same cycle, the miss queue receives n and the write queue receives n+1.
- R10: With READ_ONLY set, a write-queue allocation whose `wb_clean_evict` is low sets the sticky flag `ro_err`. Clean-eviction allocations do not set it, and with READ_ONLY clear the flag never rises.
- R11: An allocation into a full queue sets the sticky flag `alloc_err` and changes neither that queue's occupancy nor the sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mq_alloc | input | 1 | Allocate a miss-queue entry |
| mq_addr | input | ADDR_W | Miss allocation address |
| mq_in_service | input | 1 | Mark one miss-queue entry in service |
| wb_alloc | input | 1 | Allocate a write-queue entry |
| wb_addr | input | ADDR_W | Write allocation address |
| wb_clean_evict | input | 1 | Write allocation is a clean eviction |
| wb_in_service | input | 1 | Mark one write-queue entry in service |
| tgt_set | input | 1 | Raise the no-free-target cause |
| tgt_clr | input | 1 | Drop the no-free-target cause |
| req_valid | input | 1 | A request is presented at the port |
| mq_tag_addr | output | ADDR_W | Aligned miss allocation address |
| mq_tag_seq | output | SEQ_W | Sequence number for the miss allocation |
| wb_tag_addr | output | ADDR_W | Aligned write allocation address |
| wb_tag_seq | output | SEQ_W | Sequence number for the write allocation |
| blk_mask | output | 3 | Stall causes currently active |
| port_blocked | output | 1 | Port refuses requests |
| retry_pulse | output | 1 | One-cycle retry request after release |
| ev_count | output | 3*CNT_W | Per-cause stall-start counters |
| blk_cycles | output | 3*CNT_W | Per-cause stalled-cycle totals |
| alloc_err | output | 1 | Sticky: allocation into a full queue |
| ro_err | output | 1 | Sticky: non-clean write allocation in read-only mode |

## Verification
The bench stacks causes so that the port stays stalled after one cause clears. A design that released on any clear would drop `port_blocked` early and book too few cycles. It fires set and clear of the target cause in the same cycle, where a clear-wins design would leave the mask empty. It gives in-service marks to queues that are not full, which a design that clears on any service would turn into spurious releases. It overflows a full queue and then shows through the mask that occupancy did not rise. It also checks that a release with no refused request produces no retry pulse, and that a pulse that did fire is gone one cycle later.

// File: rtl/cache_stall_ctrl.sv
module cache_stall_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int MQ_DEPTH  = 2,
  parameter int WB_DEPTH  = 2,
  parameter int SEQ_W     = 16,
  parameter int CNT_W     = 16,
  parameter bit READ_ONLY = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mq_alloc,
  input  logic [ADDR_W-1:0]   mq_addr,
  input  logic                mq_in_service,
  input  logic                wb_alloc,
  input  logic [ADDR_W-1:0]   wb_addr,
  input  logic                wb_clean_evict,
  input  logic                wb_in_service,
  input  logic                tgt_set,
  input  logic                tgt_clr,
  input  logic                req_valid,
  output logic [ADDR_W-1:0]   mq_tag_addr,
  output logic [SEQ_W-1:0]    mq_tag_seq,
  output logic [ADDR_W-1:0]   wb_tag_addr,
  output logic [SEQ_W-1:0]    wb_tag_seq,
  output logic [2:0]          blk_mask,
  output logic                port_blocked,
  output logic                retry_pulse,
  output logic [3*CNT_W-1:0]  ev_count,
  output logic [3*CNT_W-1:0]  blk_cycles,
  output logic                alloc_err,
  output logic                ro_err
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int MQ_CW = $clog2(MQ_DEPTH + 1);
  localparam int WB_CW = $clog2(WB_DEPTH + 1);
  localparam int NC    = 3;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  logic [MQ_CW-1:0] mq_cnt, mq_cnt_d;
  logic [WB_CW-1:0] wb_cnt, wb_cnt_d;
  logic [NC-1:0]    mask_q, mask_d, set_v, clr_v, low_set, rel_v, low_rel;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] cyc_now, start_q;
  logic             must_retry;

  wire mq_full = mq_cnt == MQ_CW'(MQ_DEPTH);
  wire wb_full = wb_cnt == WB_CW'(WB_DEPTH);
  wire mq_take = mq_alloc && !mq_full;
  wire wb_take = wb_alloc && !wb_full;
  wire mq_give = mq_in_service && (mq_cnt != '0);
  wire wb_give = wb_in_service && (wb_cnt != '0);

  assign mq_cnt_d = mq_cnt + MQ_CW'(mq_take) - MQ_CW'(mq_give);
  assign wb_cnt_d = wb_cnt + WB_CW'(wb_take) - WB_CW'(wb_give);

  assign set_v = {tgt_set, wb_take && (wb_cnt_d == WB_CW'(WB_DEPTH)),
                  mq_take && (mq_cnt_d == MQ_CW'(MQ_DEPTH))};
  assign clr_v = {tgt_clr, wb_give && wb_full, mq_give && mq_full};
  assign mask_d = (mask_q & ~clr_v) | set_v;

  assign low_set = set_v & (~set_v + NC'(1));
  assign rel_v   = mask_q & ~mask_d;
  assign low_rel = rel_v & (~rel_v + NC'(1));

  wire start_blk = (mask_q == '0) && (set_v != '0);
  wire end_blk   = (mask_q != '0) && (mask_d == '0);
  wire refused   = port_blocked && req_valid;

  assign port_blocked = |mask_q;
  assign blk_mask     = mask_q;
  assign mq_tag_addr  = mq_addr & ALIGN_MASK;
  assign wb_tag_addr  = wb_addr & ALIGN_MASK;
  assign mq_tag_seq   = seq_q;
  assign wb_tag_seq   = seq_q + SEQ_W'(mq_take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mq_cnt      <= '0;
      wb_cnt      <= '0;
      mask_q      <= '0;
      seq_q       <= '0;
      cyc_now     <= '0;
      start_q     <= '0;
      must_retry  <= 1'b0;
      retry_pulse <= 1'b0;
      alloc_err   <= 1'b0;
      ro_err      <= 1'b0;
    end else begin
      mq_cnt      <= mq_cnt_d;
      wb_cnt      <= wb_cnt_d;
      mask_q      <= mask_d;
      seq_q       <= seq_q + SEQ_W'(mq_take) + SEQ_W'(wb_take);
      cyc_now     <= cyc_now + CNT_W'(1);
      if (start_blk) start_q <= cyc_now;
      must_retry  <= end_blk ? 1'b0 : (must_retry || refused);
      retry_pulse <= end_blk && (must_retry || refused);
      if ((mq_alloc && mq_full) || (wb_alloc && wb_full)) alloc_err <= 1'b1;
      if (READ_ONLY && wb_alloc && !wb_clean_evict) ro_err <= 1'b1;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_cause
    logic [CNT_W-1:0] ev_q, cyc_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ev_q  <= '0;
        cyc_q <= '0;
      end else begin
        if (start_blk && low_set[i]) ev_q <= ev_q + CNT_W'(1);
        if (end_blk && low_rel[i])   cyc_q <= cyc_q + (cyc_now - start_q);
      end
    end
    assign ev_count[i*CNT_W +: CNT_W]   = ev_q;
    assign blk_cycles[i*CNT_W +: CNT_W] = cyc_q;
  end
endmodule

module cache_stall_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mq_in_service,
  input logic               tgt_set,
  input logic [2:0]         blk_mask,
  input logic               port_blocked,
  input logic               retry_pulse,
  input logic [3*CNT_W-1:0] ev_count,
  input logic               alloc_err,
  input logic               ro_err
);
  // R3
  mq_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mask[0] && !mq_in_service) |=> blk_mask[0]);
  // R4
  tgt_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_set |=> blk_mask[2]);
  // R5
  stall_start_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_blocked) |-> (ev_count != $past(ev_count)));
  // R7
  retry_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> (!port_blocked && $past(port_blocked)));
  // R7
  retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> !retry_pulse);
  // R11
  alloc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> alloc_err);
  // R10
  ro_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_err |=> ro_err);
endmodule

bind cache_stall_ctrl cache_stall_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mq_in_service(mq_in_service), .tgt_set(tgt_set),
  .blk_mask(blk_mask), .port_blocked(port_blocked), .retry_pulse(retry_pulse),
  .ev_count(ev_count), .alloc_err(alloc_err), .ro_err(ro_err));

// File: tb/cache_stall_ctrl_tb.sv
`timescale 1ns/1ps
module cache_stall_ctrl_tb_top;
  localparam int ADDR_W = 32, SEQ_W = 16, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mq_alloc = 0, mq_in_service = 0, wb_alloc = 0, wb_clean_evict = 0;
  logic wb_in_service = 0, tgt_set = 0, tgt_clr = 0, req_valid = 0;
  logic [ADDR_W-1:0] mq_addr = '0, wb_addr = '0;

  logic [ADDR_W-1:0] mq_tag_addr, wb_tag_addr, r_mq_ta, r_wb_ta;
  logic [SEQ_W-1:0]  mq_tag_seq, wb_tag_seq, r_mq_ts, r_wb_ts;
  logic [2:0]        blk_mask, r_mask;
  logic              port_blocked, retry_pulse, alloc_err, ro_err;
  logic              r_pb, r_rp, r_ae, r_re;
  logic [3*CNT_W-1:0] ev_count, blk_cycles, r_ev, r_bc;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_ev[3], exp_cyc[3];
  int exp_seq;

  always #2.5 clk = ~clk;

  cache_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mq_alloc(mq_alloc), .mq_addr(mq_addr),
    .mq_in_service(mq_in_service), .wb_alloc(wb_alloc), .wb_addr(wb_addr),
    .wb_clean_evict(wb_clean_evict), .wb_in_service(wb_in_service),
    .tgt_set(tgt_set), .tgt_clr(tgt_clr), .req_valid(req_valid),
    .mq_tag_addr(mq_tag_addr), .mq_tag_seq(mq_tag_seq), .wb_tag_addr(wb_tag_addr),
    .wb_tag_seq(wb_tag_seq), .blk_mask(blk_mask), .port_blocked(port_blocked),
    .retry_pulse(retry_pulse), .ev_count(ev_count), .blk_cycles(blk_cycles),
    .alloc_err(alloc_err), .ro_err(ro_err));

  cache_stall_ctrl #(.READ_ONLY(1'b1)) ro_i (
    .clk(clk), .rst_n(rst_n), .mq_alloc(mq_alloc), .mq_addr(mq_addr),
    .mq_in_service(mq_in_service), .wb_alloc(wb_alloc), .wb_addr(wb_addr),
    .wb_clean_evict(wb_clean_evict), .wb_in_service(wb_in_service),
    .tgt_set(tgt_set), .tgt_clr(tgt_clr), .req_valid(req_valid),
    .mq_tag_addr(r_mq_ta), .mq_tag_seq(r_mq_ts), .wb_tag_addr(r_wb_ta),
    .wb_tag_seq(r_wb_ts), .blk_mask(r_mask), .port_blocked(r_pb),
    .retry_pulse(r_rp), .ev_count(r_ev), .blk_cycles(r_bc),
    .alloc_err(r_ae), .ro_err(r_re));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic edge1();
    @(posedge clk); #1;
    mq_alloc = 0; mq_in_service = 0; wb_alloc = 0; wb_in_service = 0;
    tgt_set = 0; tgt_clr = 0; req_valid = 0; wb_clean_evict = 0;
  endtask

  task automatic chk_counters(input string req);
    for (int i = 0; i < 3; i++) begin
      chk_eq({req, " ev"}, ev_count[i*CNT_W +: CNT_W], exp_ev[i]);
      chk_eq({req, " cyc"}, blk_cycles[i*CNT_W +: CNT_W], exp_cyc[i]);
    end
  endtask

  task automatic t_reset();
    chk_eq("R1 mask", blk_mask, 0);
    chk_eq("R1 blocked", port_blocked, 0);
    chk_eq("R1 retry", retry_pulse, 0);
    chk_eq("R1 errs", {alloc_err, ro_err, r_ae, r_re}, 0);
    chk_eq("R1 seq", mq_tag_seq, 0);
    chk_counters("R1");
  endtask

  task automatic t_miss_block();
    mq_alloc = 1; mq_addr = 32'h1234_5678; #0.1;
    chk_eq("R8 aligned", mq_tag_addr, 32'h1234_5640);
    chk_eq("R9 seq first", mq_tag_seq, exp_seq);
    edge1(); exp_seq++;
    chk_eq("R2 not full yet", blk_mask, 0);
    mq_alloc = 1; mq_addr = 32'h0000_00C0; #0.1;
    chk_eq("R9 seq next", mq_tag_seq, exp_seq);
    chk_eq("R8 aligned kept", mq_tag_addr, 32'h0000_00C0);
    edge1(); exp_seq++; exp_ev[0]++;
    chk_eq("R2 mq bit", blk_mask, 3'b001);
    chk_eq("R6 blocked", port_blocked, 1);
    chk_counters("R5");
    req_valid = 1; edge1();
    edge1(); edge1();
    chk_eq("R6 still blocked", port_blocked, 1);
    mq_in_service = 1; edge1(); exp_cyc[0] += 4;
    chk_eq("R3 cleared", blk_mask, 0);
    chk_eq("R6 released", port_blocked, 0);
    chk_eq("R7 retry", retry_pulse, 1);
    chk_counters("R6");
    mq_in_service = 1; edge1();
    chk_eq("R7 one shot", retry_pulse, 0);
    chk_eq("R3 not-full service", blk_mask, 0);
  endtask

  task automatic t_multi();
    mq_alloc = 1; edge1(); mq_alloc = 1; edge1(); exp_seq += 2; exp_ev[0]++;
    chk_eq("R2 refill", blk_mask, 3'b001);
    tgt_set = 1; edge1();
    chk_eq("R4 set", blk_mask, 3'b101);
    chk_counters("R5 no recount");
    mq_in_service = 1; edge1();
    chk_eq("R3 partial", blk_mask, 3'b100);
    chk_eq("R6 held by other cause", port_blocked, 1);
    chk_eq("R7 no early retry", retry_pulse, 0);
    tgt_clr = 1; edge1(); exp_cyc[2] += 3;
    chk_eq("R4 clear", blk_mask, 0);
    chk_eq("R7 no refused req", retry_pulse, 0);
    chk_counters("R6 last cause");
    mq_in_service = 1; edge1();
    tgt_set = 1; tgt_clr = 1; edge1(); exp_ev[2]++;
    chk_eq("R4 set wins", blk_mask, 3'b100);
    tgt_clr = 1; edge1(); exp_cyc[2] += 1;
    chk_counters("R5 R6 target");
  endtask

  task automatic t_write();
    mq_alloc = 1; wb_alloc = 1; wb_clean_evict = 1; wb_addr = 32'hABCD_EF7F; #0.1;
    chk_eq("R9 pair mq", mq_tag_seq, exp_seq);
    chk_eq("R9 pair wb", wb_tag_seq, exp_seq + 1);
    chk_eq("R8 wb aligned", wb_tag_addr, 32'hABCD_EF40);
    edge1(); exp_seq += 2;
    wb_alloc = 1; wb_clean_evict = 1; #0.1;
    chk_eq("R9 wb alone", wb_tag_seq, exp_seq);
    edge1(); exp_seq++; exp_ev[1]++;
    chk_eq("R2 wb bit", blk_mask, 3'b010);
    wb_in_service = 1; edge1(); exp_cyc[1] += 1;
    chk_eq("R3 wb clear", blk_mask, 0);
    chk_counters("R6 wb");
    wb_in_service = 1; mq_in_service = 1; edge1();
    chk_eq("R3 drain", blk_mask, 0);
  endtask

  task automatic t_overflow();
    mq_alloc = 1; edge1(); mq_alloc = 1; edge1(); exp_seq += 2; exp_ev[0]++;
    chk_eq("R11 no err yet", alloc_err, 0);
    mq_alloc = 1; edge1();
    chk_eq("R11 err", alloc_err, 1);
    chk_eq("R11 seq unchanged", mq_tag_seq, exp_seq);
    mq_in_service = 1; edge1(); exp_cyc[0] += 2;
    chk_eq("R11 occupancy kept", blk_mask, 0);
    chk_eq("R11 sticky", alloc_err, 1);
    chk_counters("R11");
    mq_in_service = 1; edge1();
  endtask

  task automatic t_read_only();
    wb_alloc = 1; wb_clean_evict = 1; edge1();
    chk_eq("R10 clean ok", r_re, 0);
    wb_alloc = 1; wb_clean_evict = 0; edge1();
    chk_eq("R10 flagged", r_re, 1);
    chk_eq("R10 rw mode silent", ro_err, 0);
    wb_in_service = 1; edge1(); wb_in_service = 1; edge1();
    chk_eq("R10 sticky", r_re, 1);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin exp_ev[i] = 0; exp_cyc[i] = 0; end
    exp_seq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_miss_block();
    t_multi();
    t_write();
    t_overflow();
    t_read_only();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule